// File: doc/BRIEF.md
# Macro Program Sequencer with Delayed Branches

This block is the control half of a small macro engine. It owns the program counter, selects which word of a local instruction memory is presented to the decoder, and decides after every executed instruction which address runs next. Branches test an operand register for zero or non-zero and add a signed word offset to their own address. A branch can either redirect at once, discarding the sequential successor, or let that successor run first as a delay slot. An instruction marked as the last one also grants one more instruction before the run ends.

A run begins with a one-cycle start pulse. The memory read port is combinational: the decoded fields of the word at `imem_addr_o` must be valid in the same cycle. A downstream stall holds the sequencer in place. The end of a run is flagged by a one-cycle `done_o` pulse. Two sticky error flags tell apart a branch found in a delay slot and an attempt to fetch at or beyond the loaded program length.

Top module: `macro_seq_ctrl`

## Requirements
- R1: After reset `busy_o`, `done_o`, `exec_o`, `err_slot_o` and `err_range_o` are 0 and `imem_addr_o` is 0.
- R2: A `start_i` pulse while idle begins a run at address 0 on the next cycle and clears both error flags; a `start_i` pulse while a run is busy is ignored and does not alter the executed address sequence.
- R3: Condition encoding: `br_on_zero_i` = 1 takes the branch when `operand_i` equals zero, `br_on_zero_i` = 0 takes it when `operand_i` is non-zero; an untaken branch continues at the address plus 1.
- R4: The branch target is the branch's own address plus `br_offset_i` read as a two's-complement word count.
- R5: A taken branch with `br_annul_i` = 1 executes its target next; the sequential successor does not execute.
- R6: A taken branch with `br_annul_i` = 0 executes the sequential successor first (delay slot), then the target.
- R7: An instruction with `exit_i` = 1, including one that sits in a delay slot, is followed by exactly one more executed instruction (in normal execution order), after which the run ends.
- R8: A branch found in a delay slot is not executed; the run ends with `err_slot_o` = 1.
- R9: When the address to fetch is at or beyond `prog_len_i` (including a target below address 0), nothing executes there and the run ends with `err_range_o` = 1.
- R10: While `stall_i` is 1 the address is held and `exec_o` is 0; the instruction executes once the stall is released.
- R11: The end of every run produces `done_o` high for exactly one cycle with `busy_o` low; the error flags then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| prog_len_i | input | AW+1 | Number of loaded instruction words |
| stall_i | input | 1 | Downstream stall, holds the current instruction |
| imem_addr_o | output | AW | Instruction memory read address |
| is_branch_i | input | 1 | Current word is a branch |
| br_on_zero_i | input | 1 | 1: taken on zero operand, 0: taken on non-zero |
| br_annul_i | input | 1 | 1: redirect at once, 0: run a delay slot first |
| br_offset_i | input | OW | Signed word offset of the branch |
| exit_i | input | 1 | Current word ends the run after one more instruction |
| operand_i | input | DW | Value of the register the branch tests |
| busy_o | output | 1 | A run is in progress |
| exec_o | output | 1 | The word at `imem_addr_o` executes in this cycle |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| err_slot_o | output | 1 | Sticky: run ended on a branch in a delay slot |
| err_range_o | output | 1 | Sticky: run ended on an out-of-range fetch |

## Verification
The bench aims at the interplay of the two deferred actions: a non-annulled branch whose slot carries the exit bit, an exit whose slot is the redirect target, and a branch landing in a slot. A sequencer that lost the pending target would fall through to the sequential address, and one that checked slots only for exit would execute the illegal branch instead of stopping. Negative offsets that leave the program, running off the last word, and stalls held across the slot boundary are mixed into seeded random programs, where a design that advanced under stall or counted a stalled cycle as executed would produce a trace with repeated or missing addresses.

// File: rtl/macro_seq_pkg.sv
package macro_seq_pkg;

  // Reason a run came to an end.
  typedef enum logic [1:0] {
    STOP_NONE  = 2'd0,
    STOP_EXIT  = 2'd1,
    STOP_SLOT  = 2'd2,
    STOP_RANGE = 2'd3
  } stop_e;

endpackage

// File: rtl/seq_branch_eval.sv
module seq_branch_eval #(
  parameter int DW = 32,
  parameter int OW = 8,
  parameter int PW = 9
) (
  input  logic          is_branch_i,
  input  logic          on_zero_i,
  input  logic [DW-1:0] operand_i,
  input  logic [PW-1:0] pc_i,
  input  logic [OW-1:0] offset_i,
  output logic          taken_o,
  output logic [PW-1:0] target_o
);

  localparam int EXT = PW - OW;

  // Condition test on the operand register.
  function automatic logic f_taken(input logic br, input logic on_zero,
                                   input logic [DW-1:0] val);
    logic is_zero;
    is_zero = (val == '0);
    return br && (on_zero ? is_zero : !is_zero);
  endfunction

  // Own address plus a sign-extended word offset, wrapping at PW bits.
  function automatic logic [PW-1:0] f_target(input logic [PW-1:0] pc,
                                             input logic [OW-1:0] off);
    logic [PW-1:0] ext;
    ext = {{EXT{off[OW-1]}}, off};
    return pc + ext;
  endfunction

  assign taken_o  = f_taken(is_branch_i, on_zero_i, operand_i);
  assign target_o = f_target(pc_i, offset_i);

endmodule

// File: rtl/seq_slot_ctrl.sv
module seq_slot_ctrl #(
  parameter int PW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          retire_i,
  input  logic [PW-1:0] pc_i,
  input  logic          is_branch_i,
  input  logic          taken_i,
  input  logic          annul_i,
  input  logic          exit_i,
  input  logic [PW-1:0] target_i,
  output logic          in_slot_o,
  output logic          slot_branch_o,
  output logic          finish_o,
  output logic [PW-1:0] next_pc_o
);

  logic          in_slot_q;
  logic          jump_q;
  logic          exit_q;
  logic [PW-1:0] tgt_q;

  logic          in_slot_d;
  logic          jump_d;
  logic          exit_d;
  logic [PW-1:0] tgt_d;
  logic [PW-1:0] seq_pc;
  logic          defer_jump;

  assign seq_pc     = pc_i + PW'(1);
  assign defer_jump = taken_i && !annul_i;

  always_comb begin
    in_slot_d = in_slot_q;
    jump_d    = jump_q;
    exit_d    = exit_q;
    tgt_d     = tgt_q;
    next_pc_o = seq_pc;
    if (in_slot_q) begin
      // Slot instruction completes the deferred action.
      next_pc_o = jump_q ? tgt_q : seq_pc;
      in_slot_d = exit_i && !exit_q;
      exit_d    = exit_i && !exit_q;
      jump_d    = 1'b0;
    end else begin
      next_pc_o = (taken_i && annul_i) ? target_i : seq_pc;
      jump_d    = defer_jump;
      exit_d    = exit_i;
      tgt_d     = target_i;
      in_slot_d = exit_i || defer_jump;
    end
  end

  assign in_slot_o     = in_slot_q;
  assign slot_branch_o = in_slot_q && is_branch_i;
  assign finish_o      = in_slot_q && exit_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      in_slot_q <= 1'b0;
      jump_q    <= 1'b0;
      exit_q    <= 1'b0;
      tgt_q     <= '0;
    end else if (retire_i) begin
      in_slot_q <= in_slot_d;
      jump_q    <= jump_d;
      exit_q    <= exit_d;
      tgt_q     <= tgt_d;
    end
  end

  // R6: a deferred redirect only exists while a slot is pending.
  a_r6_jump_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    jump_q |-> in_slot_q);

  // R7: a slot that finishes an exit never carries a pending redirect past it.
  a_r7_exit_slot_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && finish_o) |=> !jump_q);

endmodule

// File: rtl/macro_seq_ctrl.sv
module macro_seq_ctrl #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int OW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW:0]   prog_len_i,
  input  logic          stall_i,
  output logic [AW-1:0] imem_addr_o,
  input  logic          is_branch_i,
  input  logic          br_on_zero_i,
  input  logic          br_annul_i,
  input  logic [OW-1:0] br_offset_i,
  input  logic          exit_i,
  input  logic [DW-1:0] operand_i,
  output logic          busy_o,
  output logic          exec_o,
  output logic          done_o,
  output logic          err_slot_o,
  output logic          err_range_o
);
  import macro_seq_pkg::*;

  localparam int PW = AW + 1;

  logic [PW-1:0] pc_q;
  logic          busy_q;
  logic          done_q;
  logic          err_slot_q;
  logic          err_range_q;

  logic          accept_start;
  logic          in_range;
  logic          br_taken;
  logic [PW-1:0] br_target;
  logic          in_slot;
  logic          slot_branch;
  logic          finish;
  logic [PW-1:0] next_pc;
  stop_e         stop_cause;

  assign accept_start = start_i && !busy_q;
  assign in_range     = (pc_q < prog_len_i);
  assign exec_o       = busy_q && in_range && !stall_i && !slot_branch;

  seq_branch_eval #(.DW(DW), .OW(OW), .PW(PW)) u_branch (
    .is_branch_i (is_branch_i),
    .on_zero_i   (br_on_zero_i),
    .operand_i   (operand_i),
    .pc_i        (pc_q),
    .offset_i    (br_offset_i),
    .taken_o     (br_taken),
    .target_o    (br_target)
  );

  seq_slot_ctrl #(.PW(PW)) u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (accept_start),
    .retire_i      (exec_o),
    .pc_i          (pc_q),
    .is_branch_i   (is_branch_i),
    .taken_i       (br_taken),
    .annul_i       (br_annul_i),
    .exit_i        (exit_i),
    .target_i      (br_target),
    .in_slot_o     (in_slot),
    .slot_branch_o (slot_branch),
    .finish_o      (finish),
    .next_pc_o     (next_pc)
  );

  // Why the current cycle ends the run, if it does.
  always_comb begin
    stop_cause = STOP_NONE;
    if (busy_q) begin
      if (!in_range)                         stop_cause = STOP_RANGE;
      else if (!stall_i && slot_branch)      stop_cause = STOP_SLOT;
      else if (!stall_i && finish)           stop_cause = STOP_EXIT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q        <= '0;
      busy_q      <= 1'b0;
      done_q      <= 1'b0;
      err_slot_q  <= 1'b0;
      err_range_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_start) begin
        pc_q        <= '0;
        busy_q      <= 1'b1;
        err_slot_q  <= 1'b0;
        err_range_q <= 1'b0;
      end else if (stop_cause != STOP_NONE) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (stop_cause == STOP_SLOT)  err_slot_q  <= 1'b1;
        if (stop_cause == STOP_RANGE) err_range_q <= 1'b1;
      end else if (exec_o) begin
        pc_q <= next_pc;
      end
    end
  end

  assign imem_addr_o = pc_q[AW-1:0];
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_slot_o  = err_slot_q;
  assign err_range_o = err_range_q;

  // R2: an accepted start begins at address 0 with clear flags.
  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && pc_q == '0 && !err_slot_o && !err_range_o));

  // R2: a start while busy does not move the address.
  a_r2_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !exec_o && in_range && !slot_branch) |=> $stable(pc_q));

  // R3: an untaken branch outside a slot advances by one.
  a_r3_untaken_step: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && !in_slot && is_branch_i && !br_taken) |=> (pc_q == $past(pc_q) + PW'(1)));

  // R5: an annulled taken branch lands on its target with no slot.
  a_r5_annul_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && !in_slot && br_taken && br_annul_i && !exit_i)
      |=> (busy_o && pc_q == $past(br_target) && !in_slot));

  // R6: a plain taken branch runs its successor as a slot.
  a_r6_slot_entered: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_o && !in_slot && br_taken && !br_annul_i)
      |=> (in_slot && pc_q == $past(pc_q) + PW'(1)));

  // R8: a branch in a slot stops the run with the slot error.
  a_r8_slot_branch_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && in_range && !stall_i && in_slot && is_branch_i)
      |=> (done_o && err_slot_o && !busy_o));

  // R9: an out-of-range fetch stops the run with the range error.
  a_r9_range_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !in_range) |=> (done_o && err_range_o && !busy_o));

  // R10: a stall holds the address and the run.
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && in_range && stall_i) |=> (busy_o && $stable(pc_q)));

  // R10: nothing executes under stall.
  a_r10_no_exec_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |-> !exec_o);

  // R11: done is a single-cycle pulse with the run idle.
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o ##1 !done_o));

endmodule

// File: tb/test_macro_seq_ctrl.sv
module test_macro_seq_ctrl;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int OW = 8;
  localparam int MAXP = 16;
  localparam int MAXT = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [AW:0]   prog_len_i = '0;
  logic          stall_i = 1'b0;
  logic [AW-1:0] imem_addr_o;
  logic          is_branch_i = 1'b0;
  logic          br_on_zero_i = 1'b0;
  logic          br_annul_i = 1'b0;
  logic [OW-1:0] br_offset_i = '0;
  logic          exit_i = 1'b0;
  logic [DW-1:0] operand_i = '0;
  logic          busy_o, exec_o, done_o, err_slot_o, err_range_o;

  always #2.5 clk = ~clk;

  macro_seq_ctrl #(.AW(AW), .DW(DW), .OW(OW)) i_macro_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .prog_len_i(prog_len_i),
    .stall_i(stall_i), .imem_addr_o(imem_addr_o), .is_branch_i(is_branch_i),
    .br_on_zero_i(br_on_zero_i), .br_annul_i(br_annul_i), .br_offset_i(br_offset_i),
    .exit_i(exit_i), .operand_i(operand_i), .busy_o(busy_o), .exec_o(exec_o),
    .done_o(done_o), .err_slot_o(err_slot_o), .err_range_o(err_range_o)
  );

  int n_tests = 0;
  int n_fail = 0;

  // Program image held by the bench.
  bit          p_br [MAXP];
  bit          p_zero [MAXP];
  bit          p_ann [MAXP];
  int          p_off [MAXP];
  bit          p_ex [MAXP];
  logic [31:0] p_val [MAXP];
  int          len;

  int exp_tr [MAXT];
  int exp_n;
  bit exp_es, exp_er, exp_ok;
  int got_tr [MAXT];
  int got_n;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < MAXP; i++) begin
      p_br[i] = 0; p_zero[i] = 0; p_ann[i] = 0; p_off[i] = 0; p_ex[i] = 0; p_val[i] = '0;
    end
  endtask

  task automatic set_br(input int a, input bit on_zero, input bit ann, input int off,
                        input logic [31:0] val);
    p_br[a] = 1; p_zero[a] = on_zero; p_ann[a] = ann; p_off[a] = off; p_val[a] = val;
  endtask

  // Reference interpreter written from the requirement list.
  task automatic ref_run();
    int pc = 0; int nxt; int tgt; int pt = 0;
    bit slot = 0; bit pj = 0; bit pe = 0; bit tk;
    exp_n = 0; exp_es = 0; exp_er = 0; exp_ok = 0;
    for (int step = 0; step < 100; step++) begin
      if (pc < 0 || pc >= len) begin exp_er = 1; exp_ok = 1; return; end  // R9
      if (slot && p_br[pc]) begin exp_es = 1; exp_ok = 1; return; end      // R8
      exp_tr[exp_n] = pc; exp_n++;
      tk  = p_br[pc] && (p_zero[pc] ? (p_val[pc] == 0) : (p_val[pc] != 0)); // R3
      tgt = pc + p_off[pc];                                                 // R4
      if (slot) begin
        if (pe) begin exp_ok = 1; return; end                               // R7
        nxt = pj ? pt : pc + 1;
        pe = p_ex[pc]; slot = p_ex[pc]; pj = 0;
      end else begin
        nxt = (tk && p_ann[pc]) ? tgt : pc + 1;                             // R5
        pj = tk && !p_ann[pc]; pt = tgt; pe = p_ex[pc];                     // R6
        slot = pe || pj;
      end
      pc = nxt;
    end
  endtask

  task automatic drive_word(input int a);
    if (a < len) begin
      is_branch_i = p_br[a]; br_on_zero_i = p_zero[a]; br_annul_i = p_ann[a];
      br_offset_i = OW'(p_off[a]); exit_i = p_ex[a]; operand_i = p_val[a];
    end else begin
      is_branch_i = 0; br_on_zero_i = 0; br_annul_i = 0;
      br_offset_i = '0; exit_i = 0; operand_i = '0;
    end
  endtask

  task automatic run_prog(input string tag, input bit use_stall, input bit restart_mid);
    int cyc = 0; bit got_done = 0; bit prev_stall = 0; int prev_addr = 0; int a;
    ref_run();
    prog_len_i = (AW+1)'(len);
    @(negedge clk); start_i = 1; drive_word(0);
    @(negedge clk); start_i = 0;
    got_n = 0;
    while (cyc < 400) begin
      if (done_o) begin got_done = 1; break; end
      a = int'(imem_addr_o);
      if (prev_stall)
        check(a == prev_addr, "R10", "address moved under stall", a, prev_addr);
      drive_word(a);
      stall_i = use_stall && ($urandom % 4 == 0);
      start_i = restart_mid && (cyc == 3);   // R2 start while busy
      #1;
      if (stall_i) check(!exec_o, "R10", "exec under stall", exec_o, 0);
      if (exec_o && got_n < MAXT) begin got_tr[got_n] = a; got_n++; end
      prev_stall = stall_i && busy_o && (a < len);
      prev_addr  = a;
      @(negedge clk); cyc++;
    end
    start_i = 0; stall_i = 0;
    check(got_done, "R11", {tag, " done seen"}, got_done, 1);
    check(!busy_o, "R11", {tag, " idle at done"}, busy_o, 0);
    check(got_n == exp_n, tag, "trace length", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got_tr[i] == exp_tr[i], tag, $sformatf("trace[%0d]", i), got_tr[i], exp_tr[i]);
    check(err_slot_o == exp_es, tag, "slot error flag (R8)", err_slot_o, exp_es);
    check(err_range_o == exp_er, tag, "range error flag (R9)", err_range_o, exp_er);
    @(negedge clk);
    check(!done_o, "R11", {tag, " done one cycle"}, done_o, 0);
    check(err_slot_o == exp_es && err_range_o == exp_er, "R11", {tag, " flags held"},
          {err_slot_o, err_range_o}, {exp_es, exp_er});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check(!busy_o && !done_o && !exec_o, "R1", "control outputs", {busy_o, done_o, exec_o}, 0);
    check(!err_slot_o && !err_range_o, "R1", "error flags", {err_slot_o, err_range_o}, 0);
    check(imem_addr_o == '0, "R1", "address", int'(imem_addr_o), 0);

    // R3 untaken: on-zero with non-zero operand, then on-nonzero with zero operand
    clear_prog(); len = 5;
    set_br(0, 1, 0, 3, 32'd5); set_br(1, 0, 1, 3, 32'd0); p_ex[2] = 1;
    run_prog("R3", 0, 0);

    // R5/R4 annulled taken forward
    clear_prog(); len = 6;
    set_br(0, 0, 1, 3, 32'd7); p_ex[3] = 1;
    run_prog("R5", 0, 0);

    // R6 non-annulled taken: slot then target
    clear_prog(); len = 7;
    set_br(0, 1, 0, 4, 32'd0); p_ex[4] = 1;
    run_prog("R6", 0, 0);

    // R7 exit plus one
    clear_prog(); len = 5;
    p_ex[1] = 1;
    run_prog("R7", 0, 0);

    // R8 branch in slot
    clear_prog(); len = 4;
    set_br(0, 0, 0, 2, 32'd1); set_br(1, 1, 1, 1, 32'd0);
    run_prog("R8", 0, 0);

    // R9 run past the last word; also checks R2 flag clear on start
    clear_prog(); len = 3;
    run_prog("R9", 0, 0);

    // R4/R9 negative target leaving the program
    clear_prog(); len = 4;
    set_br(1, 1, 1, -2, 32'd0);
    run_prog("R4", 0, 0);

    // R7 exit in a backward branch's slot: target becomes the final word
    clear_prog(); len = 6;
    set_br(2, 0, 0, -2, 32'd3); p_ex[3] = 1;
    run_prog("R7", 0, 0);

    // R2 start while busy ignored, with stalls (R10)
    clear_prog(); len = 9;
    set_br(0, 1, 0, 5, 32'd0); p_ex[6] = 1;
    run_prog("R2", 1, 1);

    // Random programs
    for (int t = 0; t < 40; t++) begin
      int tries = 0;
      do begin
        clear_prog();
        len = 4 + int'($urandom % 9);
        for (int i = 0; i < len; i++) begin
          int r = int'($urandom % 100);
          if (r < 30) set_br(i, bit'($urandom % 2), bit'($urandom % 2),
                             int'($urandom % 9) - 3,
                             ($urandom % 2) ? 32'd0 : $urandom);
          if (int'($urandom % 100) < 15) p_ex[i] = 1;
        end
        ref_run();
        tries++;
      end while (!exp_ok && tries < 50);
      if (exp_ok) run_prog("R6", 1, (t % 5) == 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule